// File: doc/BRIEF.md
# Reconfiguration Data Push Controller

This block is a register-mapped front end for a partial-reconfiguration engine. Host software drives a reconfiguration session through one 64-bit control register. It uses that register to reset the engine, pick a target region, open the session and, once every word has been pushed, announce that the image is complete. Image words are written one at a time to a data register. They are held in an internal queue and leave the block on a valid/ready stream toward the engine.

Software paces its writes from a free-entry count that it reads from the status register. A write that breaks the session rules is dropped and flagged, and so is a write that finds the queue full. The engine reports operation, CRC and image-compatibility faults on single-cycle pulse inputs. Faults are kept in an error register until software clears them by writing 1 to the matching bits. The session closes in hardware: once completion is flagged and the queue has drained, the start and completion bits fall together and the busy flag drops.

Top module: `recfg_push_ctrl`

## Requirements
- R1: Reads decode the byte address: 0x00 returns the header constant, 0xA8 the upper interface-ID half, 0xB0 the lower half, 0x08 control, 0x10 status, 0x20 error; any other address reads zero.
- R2: Writing control bit 0 as 1 makes control bit 4 (reset acknowledge) read 1 from the following cycle on; writing bit 0 as 0 makes bit 4 read 0 from the following cycle on.
- R3: While control bit 0 is set the queue is flushed (status credit returns to the queue depth, sink valid low), control bits 12 and 13 are cleared, and the error register keeps its value.
- R4: Control bits 9:7 hold a 3-bit region number that software writes and reads back; it is driven on `snk_region_o`.
- R5: Writing control bit 12 as 1 opens a session; status bit 16 reads 1 while bit 12 or bit 0 is set and 0 otherwise.
- R6: Status bits 8:0 give the number of free queue entries: the depth (default 256) after reset, one less for each accepted write to 0x18, one more for each sink transfer.
- R7: Accepted words leave on `snk_data_o` in write order, one per cycle with `snk_valid_o` and `snk_ready_i` both high; while ready is low, valid and data hold.
- R8: After control bit 13 is written as 1 during a session, hardware clears bits 12 and 13 in the same cycle once the queue is empty, and status bit 16 then reads 0.
- R9: A write to 0x18 while bit 12 is clear, while bit 13 is set, or during reset sets error bit 3 and the word is dropped (credit unchanged).
- R10: A write to 0x18 that is otherwise legal but finds zero credit sets error bit 4 and the word is dropped.
- R11: A one-cycle pulse on `err_op_i`, `err_crc_i` or `err_incompat_i` sets error bit 0, 1 or 2 respectively.
- R12: Writing to 0x20 clears exactly the error bits written as 1; a fault raised in the same cycle as its clear stays set.
- R13: Status bits 22:20 mirror `ctrl_state_i` and bits 27:24 mirror `host_state_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register byte address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data for `reg_addr_i` (combinational) |
| snk_data_o | output | 32 | Image word toward the engine |
| snk_valid_o | output | 1 | Image word valid |
| snk_ready_i | input | 1 | Engine accepts the word |
| snk_region_o | output | 3 | Selected target region |
| eng_rst_o | output | 1 | Engine reset request (control bit 0) |
| ctrl_state_i | input | 3 | Engine controller state, reported in status |
| host_state_i | input | 4 | Engine host-side state, reported in status |
| err_op_i | input | 1 | Operation fault pulse |
| err_crc_i | input | 1 | CRC fault pulse |
| err_incompat_i | input | 1 | Incompatible image pulse |

## Verification
A corrupt entry count shows up at once in status bits 8:0 and, within one image, as a full queue that comes early or late or as a session that never closes. A wrong read or write pointer appears on the first sink transfer after it, as a word out of order or a repeated word. A handshake state that does not return to idle shows up as bit 12 or bit 16 still set a few cycles after the drain. A reset that does not flush leaves credit below the depth on the next status read. Error bookkeeping faults are visible on the first read of 0x20 after the stimulus.

// File: rtl/recfg_pkg.sv
package recfg_pkg;
  localparam int unsigned REG_W    = 64;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned CREDIT_W = 9;
  localparam int unsigned ERR_W    = 5;

  localparam logic [7:0] ADDR_HDR   = 8'h00;
  localparam logic [7:0] ADDR_CTRL  = 8'h08;
  localparam logic [7:0] ADDR_STS   = 8'h10;
  localparam logic [7:0] ADDR_DATA  = 8'h18;
  localparam logic [7:0] ADDR_ERR   = 8'h20;
  localparam logic [7:0] ADDR_ID_HI = 8'hA8;
  localparam logic [7:0] ADDR_ID_LO = 8'hB0;

  // control bits
  localparam int unsigned C_RST   = 0;
  localparam int unsigned C_ACK   = 4;
  localparam int unsigned C_RGN_L = 7;
  localparam int unsigned C_START = 12;
  localparam int unsigned C_DONE  = 13;

  // status bits
  localparam int unsigned S_BUSY  = 16;
  localparam int unsigned S_CST_L = 20;
  localparam int unsigned S_HST_L = 24;

  typedef enum int unsigned {
    E_OP     = 0,
    E_CRC    = 1,
    E_INCOMP = 2,
    E_PROTO  = 3,
    E_OVF    = 4
  } err_idx_e;
endpackage

// File: rtl/recfg_queue.sv
module recfg_queue #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign data_o  = mem[rd_ptr];
  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign count_o = cnt;
endmodule

// File: rtl/recfg_ctrl.sv
module recfg_ctrl
  import recfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             drained_i,
  output logic             rst_req_o,
  output logic             ack_o,
  output logic [2:0]       region_o,
  output logic             start_o,
  output logic             done_o
);
  logic rst_q, ack_q, start_q, done_q;
  logic [2:0] rgn_q;
  logic close;

  // session closes once completion is flagged and nothing is left queued
  assign close = start_q & done_q & drained_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q   <= 1'b0;
      ack_q   <= 1'b0;
      rgn_q   <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ack_q <= rst_q;
      if (we_i) begin
        rst_q <= wdata_i[C_RST];
        rgn_q <= wdata_i[C_RGN_L +: 3];
      end
      if ((we_i && wdata_i[C_RST]) || rst_q) begin
        start_q <= 1'b0;
        done_q  <= 1'b0;
      end else begin
        if (close) begin
          start_q <= 1'b0;
          done_q  <= 1'b0;
        end
        if (we_i && wdata_i[C_START]) start_q <= 1'b1;
        if (we_i && wdata_i[C_DONE] && (start_q || wdata_i[C_START])) done_q <= 1'b1;
      end
    end
  end

  assign rst_req_o = rst_q;
  assign ack_o     = ack_q;
  assign region_o  = rgn_q;
  assign start_o   = start_q;
  assign done_o    = done_q;
endmodule

// File: rtl/recfg_errlog.sv
module recfg_errlog #(
  parameter int unsigned NB = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] set_i,
  input  logic [NB-1:0] clr_i,
  output logic [NB-1:0] err_o
);
  logic [NB-1:0] err_q;

  // a fault in the clearing cycle survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else         err_q <= (err_q & ~clr_i) | set_i;
  end

  assign err_o = err_q;
endmodule

// File: rtl/recfg_push_ctrl.sv
module recfg_push_ctrl
  import recfg_pkg::*;
#(
  parameter int unsigned DEPTH     = 256,
  parameter logic [63:0] HDR_VALUE = 64'h3000_0000_1000_0005,
  parameter logic [63:0] ID_HI     = 64'hA5A5_0001_C3C3_0002,
  parameter logic [63:0] ID_LO     = 64'h5A5A_0003_3C3C_0004
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  reg_addr_i,
  input  logic        reg_we_i,
  input  logic [63:0] reg_wdata_i,
  output logic [63:0] reg_rdata_o,
  output logic [31:0] snk_data_o,
  output logic        snk_valid_o,
  input  logic        snk_ready_i,
  output logic [2:0]  snk_region_o,
  output logic        eng_rst_o,
  input  logic [2:0]  ctrl_state_i,
  input  logic [3:0]  host_state_i,
  input  logic        err_op_i,
  input  logic        err_crc_i,
  input  logic        err_incompat_i
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic ctrl_we, err_we, data_we;
  logic rst_req, ack_q, start_q, cmpl_q;
  logic [2:0] region;
  logic q_push, q_pop, q_empty, q_full;
  logic [CW-1:0] q_count, credit;
  logic [WORD_W-1:0] q_data;
  logic proto_err, ovf_err;
  logic [ERR_W-1:0] err_set, err_q;
  logic [REG_W-1:0] ctrl_rd, sts_rd;

  assign ctrl_we = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign err_we  = reg_we_i && (reg_addr_i == ADDR_ERR);
  assign data_we = reg_we_i && (reg_addr_i == ADDR_DATA);

  recfg_ctrl i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctrl_we),
    .wdata_i   (reg_wdata_i),
    .drained_i (q_empty),
    .rst_req_o (rst_req),
    .ack_o     (ack_q),
    .region_o  (region),
    .start_o   (start_q),
    .done_o    (cmpl_q)
  );

  // data push admission: session rules first, then space
  assign proto_err = data_we && (!start_q || cmpl_q || rst_req);
  assign ovf_err   = data_we && !proto_err && q_full;
  assign q_push    = data_we && !proto_err && !q_full;
  assign q_pop     = snk_valid_o && snk_ready_i;

  recfg_queue #(.DEPTH(DEPTH), .W(WORD_W)) i_queue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rst_req),
    .push_i  (q_push),
    .data_i  (reg_wdata_i[WORD_W-1:0]),
    .pop_i   (q_pop),
    .data_o  (q_data),
    .empty_o (q_empty),
    .full_o  (q_full),
    .count_o (q_count)
  );

  assign credit = CW'(DEPTH) - q_count;

  always_comb begin
    err_set         = '0;
    err_set[E_OP]     = err_op_i;
    err_set[E_CRC]    = err_crc_i;
    err_set[E_INCOMP] = err_incompat_i;
    err_set[E_PROTO]  = proto_err;
    err_set[E_OVF]    = ovf_err;
  end

  recfg_errlog #(.NB(ERR_W)) i_errlog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_set),
    .clr_i  (err_we ? reg_wdata_i[ERR_W-1:0] : '0),
    .err_o  (err_q)
  );

  always_comb begin
    ctrl_rd                 = '0;
    ctrl_rd[C_RST]          = rst_req;
    ctrl_rd[C_ACK]          = ack_q;
    ctrl_rd[C_RGN_L +: 3]   = region;
    ctrl_rd[C_START]        = start_q;
    ctrl_rd[C_DONE]         = cmpl_q;
    sts_rd                  = '0;
    sts_rd[CREDIT_W-1:0]    = CREDIT_W'(credit);
    sts_rd[S_BUSY]          = start_q | rst_req;
    sts_rd[S_CST_L +: 3]    = ctrl_state_i;
    sts_rd[S_HST_L +: 4]    = host_state_i;
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_HDR:   reg_rdata_o = HDR_VALUE;
      ADDR_CTRL:  reg_rdata_o = ctrl_rd;
      ADDR_STS:   reg_rdata_o = sts_rd;
      ADDR_ERR:   reg_rdata_o = {{(REG_W-ERR_W){1'b0}}, err_q};
      ADDR_ID_HI: reg_rdata_o = ID_HI;
      ADDR_ID_LO: reg_rdata_o = ID_LO;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign snk_data_o   = q_data;
  assign snk_valid_o  = !q_empty && !rst_req;
  assign snk_region_o = region;
  assign eng_rst_o    = rst_req;
endmodule

// File: rtl/recfg_push_ctrl_chk.sv
module recfg_push_ctrl_chk #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          snk_valid_o,
  input logic          snk_ready_i,
  input logic [31:0]   snk_data_o,
  input logic          rst_req,
  input logic          ack_q,
  input logic          start_q,
  input logic          cmpl_q,
  input logic [CW-1:0] credit,
  input logic          data_we,
  input logic          proto_err,
  input logic          ctrl_we,
  input logic [63:0]   reg_wdata_i,
  input logic          q_push,
  input logic          q_pop,
  input logic [4:0]    err_q,
  input logic          err_op_i
);
  assert_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req |=> ack_q);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snk_valid_o && !snk_ready_i && !rst_req && !(ctrl_we && reg_wdata_i[0]))
      |=> (snk_valid_o && $stable(snk_data_o)));

  assert_credit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_push && !q_pop) |=> (credit == $past(credit) - 1'b1));

  assert_close_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(start_q) && !$past(rst_req) && !$past(ctrl_we && reg_wdata_i[0]))
      |-> ($fell(cmpl_q) && credit == CW'(DEPTH)));

  assert_proto_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we && !start_q) |=> err_q[3]);

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we && !proto_err && credit == '0) |=> err_q[4]);

  assert_op_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_op_i |=> err_q[0]);

  always @(posedge clk_i) begin
    if (rst_ni) assert_credit_range_R6: assert (credit <= CW'(DEPTH));
  end
endmodule

bind recfg_push_ctrl recfg_push_ctrl_chk #(.DEPTH(DEPTH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .snk_valid_o (snk_valid_o),
  .snk_ready_i (snk_ready_i),
  .snk_data_o  (snk_data_o),
  .rst_req     (rst_req),
  .ack_q       (ack_q),
  .start_q     (start_q),
  .cmpl_q      (cmpl_q),
  .credit      (credit),
  .data_we     (data_we),
  .proto_err   (proto_err),
  .ctrl_we     (ctrl_we),
  .reg_wdata_i (reg_wdata_i),
  .q_push      (q_push),
  .q_pop       (q_pop),
  .err_q       (err_q),
  .err_op_i    (err_op_i)
);

// File: tb/test_recfg_push_ctrl.sv
module test_recfg_push_ctrl;
  localparam int unsigned DEPTH = 256;
  localparam logic [63:0] HDR = 64'h3000_0000_1000_0005;
  localparam logic [63:0] IDH = 64'hA5A5_0001_C3C3_0002;
  localparam logic [63:0] IDL = 64'h5A5A_0003_3C3C_0004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [31:0] sdata;
  logic        svalid;
  logic        sready = 1'b0;
  logic [2:0]  sregion;
  logic        erst;
  logic [2:0]  cst = '0;
  logic [3:0]  hst = '0;
  logic        e_op = 1'b0, e_crc = 1'b0, e_inc = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  recfg_push_ctrl #(.DEPTH(DEPTH), .HDR_VALUE(HDR), .ID_HI(IDH), .ID_LO(IDL)) i_recfg_push_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .snk_data_o(sdata),
    .snk_valid_o(svalid), .snk_ready_i(sready), .snk_region_o(sregion),
    .eng_rst_o(erst), .ctrl_state_i(cst), .host_state_i(hst),
    .err_op_i(e_op), .err_crc_i(e_crc), .err_incompat_i(e_inc)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_state;
    logic [63:0] v;
    rd(8'h08, v); chk("R2 ctrl after reset", v, 64'h0);
    rd(8'h10, v); chk("R6 credit after reset", v, 64'd256);
    rd(8'h20, v); chk("R11 err after reset", v, 64'h0);
    chk("R7 valid after reset", {63'h0, svalid}, 64'h0);
    rd(8'h00, v); chk("R1 header", v, HDR);
    rd(8'hA8, v); chk("R1 id high", v, IDH);
    rd(8'hB0, v); chk("R1 id low", v, IDL);
    rd(8'h28, v); chk("R1 unmapped", v, 64'h0);
  endtask

  task automatic t_state_pins;
    logic [63:0] v;
    cst = 3'd5; hst = 4'd9;
    rd(8'h10, v); chk("R13 state mirror", v, 64'h0950_0100);
    cst = 3'd0; hst = 4'd0;
  endtask

  task automatic t_reset_handshake;
    logic [63:0] v;
    wr(8'h08, 64'h1);
    rd(8'h08, v); chk("R2 ack set", v, 64'h11);
    chk("R2 engine reset pin", {63'h0, erst}, 64'h1);
    rd(8'h10, v); chk("R5 busy during reset", v, 64'h1_0100);
    wr(8'h08, 64'h0);
    rd(8'h08, v); chk("R2 ack dropped", v, 64'h0);
  endtask

  task automatic t_protocol;
    logic [63:0] v;
    wr(8'h18, 64'hDEAD);
    rd(8'h20, v); chk("R9 push without start", v, 64'h8);
    rd(8'h10, v); chk("R9 word dropped", v, 64'd256);
    wr(8'h20, 64'h8);
    rd(8'h20, v); chk("R12 clear", v, 64'h0);
  endtask

  task automatic t_push_drain;
    logic [63:0] v;
    logic [31:0] exp_w [4];
    int got;
    for (int i = 0; i < 4; i++) exp_w[i] = 32'hC0DE_0000 + 32'(i * 17 + 3);
    wr(8'h08, (64'd5 << 7) | (64'h1 << 12));
    rd(8'h08, v); chk("R4 R5 ctrl readback", v, 64'h1280);
    chk("R4 region pin", {61'h0, sregion}, 64'd5);
    rd(8'h10, v); chk("R5 busy in session", v, 64'h1_0100);
    for (int i = 0; i < 4; i++) wr(8'h18, {32'hFFFF_FFFF, exp_w[i]});
    rd(8'h10, v); chk("R6 credit after 4", v, 64'h1_00FC);
    chk("R7 head word", {32'h0, sdata}, {32'h0, exp_w[0]});
    idle(3);
    chk("R7 held while stalled", {31'h0, svalid, sdata}, {31'h0, 1'b1, exp_w[0]});
    wr(8'h08, (64'd5 << 7) | (64'h1 << 12) | (64'h1 << 13));
    wr(8'h18, 64'h1234);
    rd(8'h20, v); chk("R9 push after complete", v, 64'h8);
    rd(8'h10, v); chk("R9 credit unchanged", v, 64'h1_00FC);
    wr(8'h20, 64'h1F);
    got = 0;
    @(negedge clk); sready = 1'b1;
    for (int c = 0; c < 20 && got < 4; c++) begin
      #1;
      if (svalid) begin
        chk("R7 order", {32'h0, sdata}, {32'h0, exp_w[got]});
        got++;
      end
      @(negedge clk);
    end
    sready = 1'b0;
    chk("R7 word count", 64'(got), 64'd4);
    idle(3);
    rd(8'h08, v); chk("R8 start and done cleared", v, 64'h280);
    rd(8'h10, v); chk("R8 idle full credit", v, 64'd256);
  endtask

  task automatic t_overflow_and_flush;
    logic [63:0] v;
    wr(8'h08, 64'h1 << 12);
    for (int i = 0; i < DEPTH; i++) wr(8'h18, 64'(i));
    rd(8'h10, v); chk("R6 credit zero", v, 64'h1_0000);
    rd(8'h20, v); chk("R10 no error when filling", v, 64'h0);
    wr(8'h18, 64'hBEEF);
    rd(8'h20, v); chk("R10 overflow flag", v, 64'h10);
    rd(8'h10, v); chk("R10 credit stays zero", v, 64'h1_0000);
    wr(8'h08, 64'h1);
    rd(8'h10, v); chk("R3 flushed credit", v, 64'h1_0100);
    chk("R3 valid low", {63'h0, svalid}, 64'h0);
    rd(8'h08, v); chk("R3 session cleared", v, 64'h11);
    rd(8'h20, v); chk("R3 errors kept", v, 64'h10);
    wr(8'h08, 64'h0);
    rd(8'h10, v); chk("R3 idle after release", v, 64'd256);
    wr(8'h20, 64'h10);
  endtask

  task automatic t_err_pins;
    logic [63:0] v;
    @(negedge clk); e_op = 1'b1;
    @(negedge clk); e_op = 1'b0;
    rd(8'h20, v); chk("R11 op pulse", v, 64'h1);
    @(negedge clk); e_crc = 1'b1; e_inc = 1'b1;
    @(negedge clk); e_crc = 1'b0; e_inc = 1'b0;
    rd(8'h20, v); chk("R11 crc incompat pulses", v, 64'h7);
    wr(8'h20, 64'h2);
    rd(8'h20, v); chk("R12 selective clear", v, 64'h5);
    @(negedge clk); addr = 8'h20; wdata = 64'h1; we = 1'b1; e_op = 1'b1;
    @(negedge clk); we = 1'b0; e_op = 1'b0;
    rd(8'h20, v); chk("R12 set beats clear", v, 64'h5);
    wr(8'h20, 64'h1F);
    rd(8'h20, v); chk("R12 clear all", v, 64'h0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset_state();
    t_state_pins();
    t_reset_handshake();
    t_protocol();
    t_push_drain();
    t_overflow_and_flush();
    t_err_pins();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule